// File: doc/BRIEF.md
# LCD Multiplex Frame Sequencer

This block sequences the rows of a multiplexed liquid-crystal display and decides, for every one of its outputs, which of five bias levels that output should be switched to. Rows are stepped by an external alternating reference `fr` with a 50% duty cycle. One full period of `fr` belongs to one row, so a frame lasts `MUX` periods. The multiplex ratio `MUX` is fixed at build time to 2, 4 or 8. Analog bias generation and pad drivers sit outside the block; it produces only 3-bit level-select codes.

At each falling edge of `fr` the sequencer moves to the next row and presents that row's index on `rowAddr`. It then copies the addressed display word into a display latch. Every output is treated as either a row driver or a column driver. The row driver in use is in phase with `fr`, and the column drive is the opposite. Because the polarity follows `fr`, the average drive carries no DC. A strobe input blanks every output to the top supply. It also resynchronises the frame, so that cascaded devices start row 1 together. A column-only input turns every output into a column driver.

Top module: `lcdFrameSeq`

## Requirements
- R1: While `rstN` is low, `rowAddr` is 0 and every output code is 4.
- R2: Each output code is 3 bits: 0 = ground, 1 = lowest intermediate level, 2 = middle intermediate level, 3 = highest intermediate level, 4 = top supply. No other value appears.
- R3: At each falling edge of `fr`, `rowAddr` advances by one. After `MUX-1` it wraps to 0. At no other time does `rowAddr` change.
- R4: When `colOnly` is low, outputs 0 to `MUX-1` are row drivers. Output k is the row in use when k equals the current row. That row drives code 4 while `fr` is high and code 0 while `fr` is low.
- R5: Every output that is not a row driver is a column driver fed by bit k of the display latch. A set bit drives code 0 while `fr` is high and code 4 while `fr` is low.
- R6: Idle levels depend on `MUX`. For `MUX`=8, idle rows drive 1 while `fr` is high and 3 while it is low, and cleared columns drive 2. For `MUX`=4, idle rows drive 2 or 3 and cleared columns drive 3 or 2 (`fr` high or low). For `MUX`=2, both drive 2.
- R7: When `colOnly` is high, all outputs, including 0 to `MUX-1`, are column drivers taken from the latch.
- R8: While `strobe` is high, every output code is 4.
- R9: If `strobe` has been high at any time since the previous falling edge of `fr`, including in the cycle of the edge itself, the next falling edge sets `rowAddr` to 0 instead of advancing it.
- R10: The display latch loads `rowWord` only in the cycle after a falling edge of `fr`. A change to `rowWord` during a row has no effect on the outputs until the next row starts.
- R11: Every change at `fr`, `strobe` or the loaded word reaches `driveCodes` on the third rising clock edge at which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| fr | input | 1 | Alternating frame reference, synchronous to clk |
| strobe | input | 1 | Blank and frame resynchronisation request |
| colOnly | input | 1 | High: every output is a column driver |
| rowWord | input | NUM_OUT | Display word read at `rowAddr` |
| rowAddr | output | log2(MUX) | Current row index, zero-based |
| driveCodes | output | 3*NUM_OUT | Level code per output, output k at bits 3k+2:3k |

## Verification
`rowAddr` is registered at the first clock edge that sees the new `fr` level. The display latch loads at the next edge. The output codes are registered at the third edge, and `strobe` and the `fr` phase pass through the same three stages. The bench changes inputs on a falling clock edge and waits three rising edges. It then samples on the next falling edge, so each check looks at the value due and never at a half-updated pipeline. The test of R10 changes the memory while a row is in progress and checks after the same three edges that the outputs still show the earlier word.

// File: rtl/lcdSeqPkg.sv
package lcdSeqPkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    LVL_GND  = 3'd0,
    LVL_LOW  = 3'd1,
    LVL_MID  = 3'd2,
    LVL_HIGH = 3'd3,
    LVL_TOP  = 3'd4
  } levelT;

  // strobes from the row controller to the drive datapath
  typedef struct packed {
    logic loadLatch;  // capture the addressed word this cycle
    logic phase;      // fr level, one stage delayed
    logic blank;      // strobe level, one stage delayed
  } ctrlStrobesT;

  // level table: ratio, role of the output, active flag, fr phase
  function automatic levelT pickLevel(int ratio, logic isRow, logic active, logic phase);
    levelT lvl;
    if (isRow) begin
      if (active) lvl = phase ? LVL_TOP : LVL_GND;
      else begin
        case (ratio)
          2:       lvl = LVL_MID;
          4:       lvl = phase ? LVL_MID : LVL_HIGH;
          default: lvl = phase ? LVL_LOW : LVL_HIGH;
        endcase
      end
    end else begin
      if (active) lvl = phase ? LVL_GND : LVL_TOP;
      else begin
        case (ratio)
          4:       lvl = phase ? LVL_HIGH : LVL_MID;
          default: lvl = LVL_MID;
        endcase
      end
    end
    return lvl;
  endfunction

endpackage

// File: rtl/frameCtrl.sv
module frameCtrl
  import lcdSeqPkg::*;
#(
  parameter int MUX   = 8,
  parameter int ROW_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fr,
  input  logic              strobe,
  output logic [ROW_W-1:0]  rowIdx,
  output ctrlStrobesT       strobes
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(MUX - 1);

  logic frQ;
  logic strbQ;
  logic loadPend;
  logic syncPend;
  logic frFall;
  logic syncNow;

  assign frFall  = frQ & ~fr;
  assign syncNow = syncPend | strobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frQ      <= 1'b0;
      strbQ    <= 1'b0;
      loadPend <= 1'b0;
      syncPend <= 1'b0;
      rowIdx   <= '0;
    end else begin
      frQ      <= fr;
      strbQ    <= strobe;
      loadPend <= frFall;
      if (frFall) begin
        syncPend <= 1'b0;
        if (syncNow || rowIdx == LAST_ROW) rowIdx <= '0;
        else                               rowIdx <= rowIdx + 1'b1;
      end else if (strobe) begin
        syncPend <= 1'b1;
      end
    end
  end

  assign strobes.loadLatch = loadPend;
  assign strobes.phase     = frQ;
  assign strobes.blank     = strbQ;

  assert_row_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    rowIdx <= LAST_ROW);

  assert_row_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frFall && !syncNow && rowIdx != LAST_ROW) |=> rowIdx == $past(rowIdx) + 1'b1);

  assert_row_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frFall && rowIdx == LAST_ROW) |=> rowIdx == '0);

  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !frFall |=> $stable(rowIdx));

  assert_resync_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frFall && syncNow) |=> rowIdx == '0);

  assert_load_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    loadPend |=> !loadPend);

endmodule

// File: rtl/driveDatapath.sv
module driveDatapath
  import lcdSeqPkg::*;
#(
  parameter int NUM_OUT = 40,
  parameter int MUX     = 8,
  parameter int ROW_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobesT               strobes,
  input  logic [ROW_W-1:0]          rowCur,
  input  logic [NUM_OUT-1:0]        rowWord,
  input  logic                      colOnly,
  output logic [NUM_OUT*CODE_W-1:0] driveCodes
);

  localparam logic [NUM_OUT*CODE_W-1:0] ALL_TOP = {NUM_OUT{LVL_TOP}};

  logic [NUM_OUT-1:0] dispLatch;
  logic [ROW_W-1:0]   rowSel;
  logic               phaseQ;
  logic               blankQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispLatch <= '0;
      rowSel    <= '0;
      phaseQ    <= 1'b0;
      blankQ    <= 1'b1;
    end else begin
      phaseQ <= strobes.phase;
      blankQ <= strobes.blank;
      if (strobes.loadLatch) begin
        dispLatch <= rowWord;
        rowSel    <= rowCur;
      end
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : gOut
    logic  rowHere;
    logic  activeHere;
    levelT code;

    if (g < MUX) begin : gRowCapable
      assign rowHere    = ~colOnly;
      assign activeHere = rowHere ? (rowSel == ROW_W'(g)) : dispLatch[g];
    end else begin : gColumn
      assign rowHere    = 1'b0;
      assign activeHere = dispLatch[g];
    end

    always_ff @(posedge clk) begin
      if (!rstN)       code <= LVL_TOP;
      else if (blankQ) code <= LVL_TOP;
      else             code <= pickLevel(MUX, rowHere, activeHere, phaseQ);
    end

    assign driveCodes[g*CODE_W +: CODE_W] = code;

    assert_code_range_R2: assert property (@(posedge clk) disable iff (!rstN)
      driveCodes[g*CODE_W +: CODE_W] <= 3'd4);
  end

  assert_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    blankQ |=> driveCodes == ALL_TOP);

  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLatch |=> $stable(dispLatch));

  assert_row_sel_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLatch |=> $stable(rowSel));

endmodule

// File: rtl/lcdFrameSeq.sv
module lcdFrameSeq
  import lcdSeqPkg::*;
#(
  parameter  int NUM_OUT = 40,
  parameter  int MUX     = 8,
  localparam int ROW_W   = (MUX > 1) ? $clog2(MUX) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      fr,
  input  logic                      strobe,
  input  logic                      colOnly,
  input  logic [NUM_OUT-1:0]        rowWord,
  output logic [ROW_W-1:0]          rowAddr,
  output logic [NUM_OUT*CODE_W-1:0] driveCodes
);

  ctrlStrobesT strobes;

  frameCtrl #(.MUX(MUX), .ROW_W(ROW_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .fr      (fr),
    .strobe  (strobe),
    .rowIdx  (rowAddr),
    .strobes (strobes)
  );

  driveDatapath #(.NUM_OUT(NUM_OUT), .MUX(MUX), .ROW_W(ROW_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rowCur     (rowAddr),
    .rowWord    (rowWord),
    .colOnly    (colOnly),
    .driveCodes (driveCodes)
  );

endmodule

// File: tb/sim_lcdFrameSeq.sv
module sim_lcdFrameSeq;

  localparam int NOUT = 40;
  localparam int NMUX = 8;
  localparam int NVEC = 25;

  // vector: {fr, strobe, colOnly, expected row[2:0]}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b110_000, 6'b000_000, 6'b100_000, 6'b000_001, 6'b100_001,
    6'b000_010, 6'b100_010, 6'b000_011, 6'b101_011, 6'b001_100,
    6'b100_100, 6'b000_101, 6'b100_101, 6'b000_110, 6'b100_110,
    6'b000_111, 6'b100_111, 6'b000_000, 6'b100_000, 6'b000_001,
    6'b110_001, 6'b100_001, 6'b000_000, 6'b100_000, 6'b000_001
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fr = 1'b0;
  logic strobe = 1'b0;
  logic colOnly = 1'b0;
  logic [NOUT-1:0]   rowWord;
  logic [2:0]        rowAddr;
  logic [NOUT*3-1:0] driveCodes;
  logic [NOUT-1:0]   mem [NMUX];

  int  checks = 0;
  int  misses = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  always_comb rowWord = mem[rowAddr];

  lcdFrameSeq #(.NUM_OUT(NOUT), .MUX(NMUX)) u0 (
    .clk        (clk),
    .rstN       (rstN),
    .fr         (fr),
    .strobe     (strobe),
    .colOnly    (colOnly),
    .rowWord    (rowWord),
    .rowAddr    (rowAddr),
    .driveCodes (driveCodes)
  );

  function automatic logic [NOUT-1:0] patternFor(int r);
    logic [NOUT-1:0] v;
    for (int j = 0; j < NOUT; j++) v[j] = ((j * 5 + r * 3) % 7) < 3;
    return v;
  endfunction

  // expected code from R4..R8 for ratio 8
  function automatic logic [2:0] expCode(int j, int r, bit ph, bit col, bit blk,
                                         logic [NOUT-1:0] w);
    if (blk) return 3'd4;
    if (!col && j < NMUX) begin
      if (j == r) return ph ? 3'd4 : 3'd0;
      return ph ? 3'd1 : 3'd3;
    end
    if (w[j]) return ph ? 3'd0 : 3'd4;
    return 3'd2;
  endfunction

  task automatic checkRow(int expRow, string req);
    checks++;
    if (rowAddr !== 3'(expRow)) begin
      misses++;
      $display("FAIL %s rowAddr actual=%0d expected=%0d", req, rowAddr, expRow);
    end
  endtask

  task automatic checkCodes(int r, bit ph, bit col, bit blk, logic [NOUT-1:0] w, string req);
    int bad = -1;
    logic [2:0] e;
    logic [2:0] a;
    for (int j = NOUT - 1; j >= 0; j--) begin
      if (driveCodes[j*3 +: 3] !== expCode(j, r, ph, col, blk, w)) bad = j;
    end
    checks++;
    if (bad >= 0) begin
      misses++;
      e = expCode(bad, r, ph, col, blk, w);
      a = driveCodes[bad*3 +: 3];
      $display("FAIL %s output %0d actual=%0d expected=%0d", req, bad, a, e);
    end
  endtask

  // drive on a falling edge, let three rising edges pass (R11), sample on a falling edge
  task automatic stepTo(bit frV, bit stbV, bit colV);
    @(negedge clk);
    fr = frV;
    strobe = stbV;
    colOnly = colV;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [NOUT-1:0] oldWord;
    logic [NOUT-1:0] newWord;
    for (int r = 0; r < NMUX; r++) mem[r] = patternFor(r);

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkRow(0, "R1");
    checkCodes(0, 1'b0, 1'b0, 1'b1, '0, "R1");
    rstN = 1'b1;

    // vector walk: R3 R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < NVEC; v++) begin
      stepTo(VEC[v][5], VEC[v][4], VEC[v][3]);
      checkRow(int'(VEC[v][2:0]), "R3/R9");
      checkCodes(int'(VEC[v][2:0]), VEC[v][5], VEC[v][3], VEC[v][4],
                 mem[VEC[v][2:0]], "R4/R5/R6/R7/R8");
    end

    // R10: memory change mid-row is not visible
    oldWord = mem[1];
    newWord = ~mem[2];
    @(negedge clk);
    mem[1] = ~oldWord;
    mem[2] = newWord;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkCodes(1, 1'b0, 1'b0, 1'b0, oldWord, "R10");
    stepTo(1'b1, 1'b0, 1'b0);
    checkCodes(1, 1'b1, 1'b0, 1'b0, oldWord, "R10");
    // R10: next row start picks up the new word
    stepTo(1'b0, 1'b0, 1'b0);
    checkRow(2, "R3");
    checkCodes(2, 1'b0, 1'b0, 1'b0, newWord, "R10");

    // R8 with column-only: blank overrides every output
    stepTo(1'b1, 1'b1, 1'b1);
    checkCodes(2, 1'b1, 1'b1, 1'b1, newWord, "R8");
    // R9: strobe taken at the same cycle as the falling edge
    stepTo(1'b0, 1'b1, 1'b0);
    checkRow(0, "R9");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      misses++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
    end
  end

endmodule